// File: doc/BRIEF.md
# Codec Clock-Mode and Power-Down Controller

This block decides how a voice codec is clocked and whether it is powered. Two of the codec's pins serve two purposes: the receive master-clock pin either carries a clock or is strapped to a level, and the receive bit-clock pin either carries a clock or selects the master-clock rate. The controller watches both pins, and the transmit master clock, with its own system clock and classifies each one as toggling or static. From that it derives asynchronous versus synchronous operation, whether the two directions share one bit clock, the master-clock rate the internal divider must assume, and whether power-down is forced.

Independently, the controller watches both frame-sync inputs. The first rising edge on either one wakes the codec, and the codec goes back to sleep once no frame-sync edge has been seen for a programmable number of system-clock cycles. The transmit data driver is kept disabled after wake-up until a second transmit frame sync has arrived, so the first frame after power-up never drives stale data onto the bus.

Top module: `codec_clkpwr_ctrl`

## Requirements
- R1: While reset is asserted, `powered_up` and `tx_permit` are 0.
- R2: A monitored pin is static once it has shown no edge for ACT_WINDOW system-clock cycles; an edge makes it toggling again. Its level while static is the level of its last sample.
- R3: When the receive master-clock pin is static high, `powered_up` and `tx_permit` are 0 whatever the frame syncs do.
- R4: `async_mode` is 1 when the receive master-clock pin toggles and 0 when it is static; a static low level allows the codec to run on the transmit master clock.
- R5: When the receive bit-clock pin is static, `shared_bclk` is 1 and `mclk_2048` equals its level (1 selects 2.048 MHz, 0 selects 1.536/1.544 MHz); when it toggles, `shared_bclk` is 0 and `mclk_2048` is 1.
- R6: The codec is powered only while the transmit master clock toggles.
- R7: With running allowed, the first rising edge on either frame sync raises `powered_up`; at that moment `tx_permit` is still 0.
- R8: `powered_up` falls FS_TIMEOUT cycles after the last frame-sync rising edge; every rising edge on either frame sync restarts that count.
- R9: `tx_permit` rises only on the second transmit frame-sync rising edge counted from the powered-down state, and is 0 whenever `powered_up` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all codec pins |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_mclk | input | 1 | Transmit master clock pin |
| rx_mclk_pdn | input | 1 | Receive master clock, or static power-down strap |
| rx_bclk_sel | input | 1 | Receive bit clock, or static master-rate select |
| tx_fsync | input | 1 | Transmit frame sync |
| rx_fsync | input | 1 | Receive frame sync |
| powered_up | output | 1 | 1 while the codec is powered |
| async_mode | output | 1 | 1 when the receive side runs on its own master clock |
| shared_bclk | output | 1 | 1 when the transmit bit clock serves both directions |
| mclk_2048 | output | 1 | Divider mode: 1 for 2.048 MHz, 0 for 1.536/1.544 MHz |
| tx_permit | output | 1 | 1 when the transmit data driver may be enabled |

## Verification
The assertions check on every cycle that the transmit permit never exists without power, that power never rises with the permit already set, that the permit only rises out of a powered cycle, that power never outlives the frame-sync timeout measured from the raw pins, and that a toggling bit-clock pin always implies the 2.048 MHz divider. Which strap level forces power-down, which level selects which divider rate, the need for a running transmit master clock, the restart of the timeout by a later pulse and the two-pulse delay of the permit are only shown by the bench scenarios, which move the pins between toggling and static states and pulse the frame syncs.

// File: rtl/codec_cpd_pkg.sv
// Shared definitions for the codec clock-mode and power-down controller.
package codec_cpd_pkg;
    // Index of each monitored dual-use or clock pin in the classifier array.
    localparam int PIN_TXM  = 0;
    localparam int PIN_RXM  = 1;
    localparam int PIN_RXB  = 2;
    localparam int NUM_PINS = 3;

    // Result of watching one pin: toggling flag and last sampled level.
    typedef struct packed {
        logic toggling;
        logic level;
    } pin_class_t;
endpackage

// File: rtl/pin_activity_classifier.sv
// Classifies one asynchronous pin as toggling or static.
// Assumes: the pin toggles at least once every WINDOW system-clock cycles
// when it carries a clock; the pin is resynchronised here with two flops.
module pin_activity_classifier
    import codec_cpd_pkg::*;
#(
    parameter int WINDOW = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    output pin_class_t cls_o
);
    localparam int CW = $clog2(WINDOW + 1);

    logic [2:0]    samp_q;
    logic [CW-1:0] quiet_q;
    logic          toggling_q;
    logic          pin_edge;

    // Resynchronise the pin and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) samp_q <= '0;
        else        samp_q <= {samp_q[1:0], pin_i};
    end

    assign pin_edge = samp_q[2] ^ samp_q[1];

    // Count quiet cycles; any edge marks the pin toggling, a full window static.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q    <= '0;
            toggling_q <= 1'b0;
        end else if (pin_edge) begin
            quiet_q    <= '0;
            toggling_q <= 1'b1;
        end else if (quiet_q == CW'(WINDOW - 1)) begin
            toggling_q <= 1'b0;
        end else begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assign cls_o = '{toggling: toggling_q, level: samp_q[2]};
endmodule

// File: rtl/clock_mode_decoder.sv
// Turns the three pin classifications into operating-mode controls.
// Assumes: a static high on the receive master-clock pin means power-down,
// and a toggling receive bit-clock pin implies the 2.048 MHz divider.
module clock_mode_decoder
    import codec_cpd_pkg::*;
(
    input  pin_class_t txm_i,
    input  pin_class_t rxm_i,
    input  pin_class_t rxb_i,
    output logic       run_ok_o,
    output logic       async_o,
    output logic       shared_bclk_o,
    output logic       mclk_2048_o
);
    // Derive mode selects and the run permission from the pin classes.
    always_comb begin
        async_o       = rxm_i.toggling;
        run_ok_o      = txm_i.toggling && (rxm_i.toggling || !rxm_i.level);
        shared_bclk_o = !rxb_i.toggling;
        mclk_2048_o   = rxb_i.toggling ? 1'b1 : rxb_i.level;
    end
endmodule

// File: rtl/fsync_activity_monitor.sv
// Powers the codec up on frame-sync activity and down after a quiet timeout;
// gates the transmit output until the second transmit frame sync.
// Assumes: both frame syncs are asynchronous to clk and last at least
// two system-clock cycles high.
module fsync_activity_monitor #(
    parameter int TIMEOUT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_fs_i,
    input  logic rx_fs_i,
    input  logic run_ok_i,
    output logic powered_o,
    output logic tx_permit_o
);
    localparam int TW = $clog2(TIMEOUT + 1);

    logic [2:0]    tx_s_q, rx_s_q;
    logic          tx_rise, rx_rise;
    logic          active_q;
    logic [TW-1:0] idle_q;
    logic [1:0]    txcnt_q;

    // Resynchronise both frame syncs with an edge-detect stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_s_q <= '0;
            rx_s_q <= '0;
        end else begin
            tx_s_q <= {tx_s_q[1:0], tx_fs_i};
            rx_s_q <= {rx_s_q[1:0], rx_fs_i};
        end
    end

    assign tx_rise = tx_s_q[1] && !tx_s_q[2];
    assign rx_rise = rx_s_q[1] && !rx_s_q[2];

    // Frame-sync activity flag with restartable idle timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idle_q   <= '0;
        end else if (tx_rise || rx_rise) begin
            active_q <= 1'b1;
            idle_q   <= '0;
        end else if (active_q) begin
            if (idle_q == TW'(TIMEOUT - 1)) begin
                active_q <= 1'b0;
                idle_q   <= '0;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    assign powered_o = run_ok_i && active_q;

    // Count transmit frame syncs since wake-up, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_ok_i)  txcnt_q <= 2'd0;
        else if (tx_rise)         txcnt_q <= !powered_o ? 2'd1 :
                                             (txcnt_q == 2'd2) ? 2'd2 : txcnt_q + 2'd1;
        else if (!powered_o)      txcnt_q <= 2'd0;
    end

    assign tx_permit_o = powered_o && (txcnt_q == 2'd2);
endmodule

// File: rtl/codec_clkpwr_ctrl.sv
// Top of the codec clock-mode and power-down controller.
// Classifies the clock/strap pins, decodes the operating mode and tracks
// frame-sync activity for automatic power management.
// Assumes: all codec pins are asynchronous to clk, which runs several times
// faster than the fastest monitored clock.
module codec_clkpwr_ctrl
    import codec_cpd_pkg::*;
#(
    parameter int ACT_WINDOW = 16,
    parameter int FS_TIMEOUT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_mclk,
    input  logic rx_mclk_pdn,
    input  logic rx_bclk_sel,
    input  logic tx_fsync,
    input  logic rx_fsync,
    output logic powered_up,
    output logic async_mode,
    output logic shared_bclk,
    output logic mclk_2048,
    output logic tx_permit
);
    logic [NUM_PINS-1:0] pins;
    pin_class_t          cls [NUM_PINS];
    logic                run_ok;

    assign pins[PIN_TXM] = tx_mclk;
    assign pins[PIN_RXM] = rx_mclk_pdn;
    assign pins[PIN_RXB] = rx_bclk_sel;

    // One activity classifier per monitored pin.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_activity_classifier #(.WINDOW(ACT_WINDOW)) u_cls (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (pins[i]),
            .cls_o (cls[i])
        );
    end

    clock_mode_decoder u_mode (
        .txm_i         (cls[PIN_TXM]),
        .rxm_i         (cls[PIN_RXM]),
        .rxb_i         (cls[PIN_RXB]),
        .run_ok_o      (run_ok),
        .async_o       (async_mode),
        .shared_bclk_o (shared_bclk),
        .mclk_2048_o   (mclk_2048)
    );

    fsync_activity_monitor #(.TIMEOUT(FS_TIMEOUT)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_fs_i     (tx_fsync),
        .rx_fs_i     (rx_fsync),
        .run_ok_i    (run_ok),
        .powered_o   (powered_up),
        .tx_permit_o (tx_permit)
    );
endmodule

// File: rtl/codec_clkpwr_ctrl_checker.sv
// Cycle-by-cycle properties of the controller, bound to its top module.
// Assumes: frame-sync pins pass through three sampling stages before use.
module codec_clkpwr_ctrl_checker #(
    parameter int FS_TIMEOUT = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic tx_fsync,
    input logic rx_fsync,
    input logic powered_up,
    input logic shared_bclk,
    input logic mclk_2048,
    input logic tx_permit
);
    localparam int LIMIT = FS_TIMEOUT + 2;
    localparam int GW    = $clog2(LIMIT + 2) + 1;

    logic [GW-1:0] since_fs_q;

    // Cycles since the last raw frame-sync rise, saturating past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     since_fs_q <= GW'(LIMIT + 1);
        else if ($rose(tx_fsync) || $rose(rx_fsync))    since_fs_q <= '0;
        else if (since_fs_q <= GW'(LIMIT))              since_fs_q <= since_fs_q + 1'b1;
    end

    assert_permit_needs_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_permit |-> powered_up);

    assert_permit_rises_powered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_permit) |-> $past(powered_up));

    assert_wake_without_permit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered_up) |-> !tx_permit);

    assert_timeout_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        powered_up |-> (since_fs_q <= GW'(LIMIT)));

    assert_bclk_clock_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !shared_bclk |-> mclk_2048);
endmodule

bind codec_clkpwr_ctrl codec_clkpwr_ctrl_checker #(.FS_TIMEOUT(FS_TIMEOUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_fsync    (tx_fsync),
    .rx_fsync    (rx_fsync),
    .powered_up  (powered_up),
    .shared_bclk (shared_bclk),
    .mclk_2048   (mclk_2048),
    .tx_permit   (tx_permit)
);

// File: tb/codec_clkpwr_ctrl_test.sv
// Scoreboard bench: the driver pushes expected output vectors, the monitor
// pops and compares them against the outputs.
// Vector order: {powered_up, async_mode, shared_bclk, mclk_2048, tx_permit}.
module codec_clkpwr_ctrl_test;
    localparam int WIN = 16;
    localparam int TMO = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_mclk = 1'b0, rx_mclk_pdn = 1'b1, rx_bclk_sel = 1'b1;
    logic tx_fsync = 1'b0, rx_fsync = 1'b0;
    logic txm_run = 1'b1, rxm_run = 1'b0, rxb_run = 1'b0;
    logic powered_up, async_mode, shared_bclk, mclk_2048, tx_permit;

    int total = 0, bad = 0;
    bit finished = 0;
    string q_rid[$];
    logic [4:0] q_exp[$];
    event chk_ev;

    always #2 clk = ~clk;
    always #9  if (txm_run) tx_mclk     = ~tx_mclk;
    always #11 if (rxm_run) rx_mclk_pdn = ~rx_mclk_pdn;
    always #13 if (rxb_run) rx_bclk_sel = ~rx_bclk_sel;

    codec_clkpwr_ctrl #(.ACT_WINDOW(WIN), .FS_TIMEOUT(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .tx_mclk(tx_mclk), .rx_mclk_pdn(rx_mclk_pdn),
        .rx_bclk_sel(rx_bclk_sel), .tx_fsync(tx_fsync), .rx_fsync(rx_fsync),
        .powered_up(powered_up), .async_mode(async_mode), .shared_bclk(shared_bclk),
        .mclk_2048(mclk_2048), .tx_permit(tx_permit)
    );

    // Driver side: queue one expected vector and wake the monitor.
    task automatic expect_out(input string rid, input logic [4:0] exp);
        @(negedge clk);
        q_rid.push_back(rid);
        q_exp.push_back(exp);
        -> chk_ev;
        #0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit on_tx);
        @(negedge clk);
        if (on_tx) tx_fsync = 1'b1; else rx_fsync = 1'b1;
        wait_cyc(3);
        if (on_tx) tx_fsync = 1'b0; else rx_fsync = 1'b0;
        wait_cyc(6);
    endtask

    // Monitor: pop each expected vector and compare with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (q_exp.size() > 0) begin
                string rid;
                logic [4:0] exp, act;
                rid = q_rid.pop_front();
                exp = q_exp.pop_front();
                act = {powered_up, async_mode, shared_bclk, mclk_2048, tx_permit};
                total++;
                if (act !== exp) begin
                    bad++;
                    $display("FAIL %s actual=%b expected=%b", rid, act, exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, classifiers idle and sampled levels zero.
        wait_cyc(4);
        expect_out("R1", 5'b00100);
        rst_n = 1'b1;

        // R2 R5: receive bit-clock strap high, master-clock strap high.
        wait_cyc(40);
        expect_out("R5", 5'b00110);
        // R3: strap high keeps the codec down despite a frame sync.
        pulse(1'b1);
        expect_out("R3", 5'b00110);
        wait_cyc(TMO + 20);

        // R4: strap low, still no frame sync -> sync mode, down.
        rx_mclk_pdn = 1'b0;
        wait_cyc(40);
        expect_out("R4", 5'b00110);
        // R7: receive frame sync wakes the codec, permit still off.
        pulse(1'b0);
        expect_out("R7", 5'b10110);
        pulse(1'b1);
        expect_out("R9", 5'b10110);
        pulse(1'b1);
        expect_out("R9", 5'b10111);

        // R8: a later pulse restarts the timeout.
        wait_cyc(TMO - 40);
        expect_out("R8", 5'b10111);
        pulse(1'b1);
        wait_cyc(TMO - 40);
        expect_out("R8", 5'b10111);
        wait_cyc(40);
        expect_out("R8", 5'b00110);

        // R9: wake again, permit only after the second transmit pulse.
        pulse(1'b1);
        expect_out("R9", 5'b10110);
        pulse(1'b1);
        expect_out("R9", 5'b10111);

        // R5: strap low selects the 1.536/1.544 MHz divider.
        rx_bclk_sel = 1'b0;
        pulse(1'b1);
        wait_cyc(40);
        expect_out("R5", 5'b10101);

        // R5: toggling bit clock -> separate bit clocks, 2.048 MHz.
        rxb_run = 1'b1;
        pulse(1'b1);
        wait_cyc(40);
        expect_out("R5", 5'b10011);

        // R4 R2: toggling receive master clock -> asynchronous mode.
        rxm_run = 1'b1;
        pulse(1'b0);
        wait_cyc(40);
        expect_out("R4", 5'b11011);

        // R3: strap back to static high forces power-down.
        rxm_run = 1'b0;
        @(negedge clk);
        rx_mclk_pdn = 1'b1;
        pulse(1'b0);
        wait_cyc(40);
        expect_out("R3", 5'b00010);

        // R6: static transmit master clock blocks power-up.
        rx_mclk_pdn = 1'b0;
        txm_run = 1'b0;
        pulse(1'b0);
        wait_cyc(40);
        expect_out("R6", 5'b00010);

        // R6 R9: clock restored -> powered, permit cleared.
        txm_run = 1'b1;
        pulse(1'b0);
        wait_cyc(40);
        expect_out("R6", 5'b10010);

        wait_cyc(4);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule